// File: doc/BRIEF.md
# PCI Agent Configuration Auto-Load Sequencer

This block holds a small bank of PCI agent configuration registers and, after a hard reset, can fill them from an external serial EEPROM over SPI. A reset-time configuration word is captured while hard reset is held low. It selects three things: whether the bridge is active at all, whether the EEPROM load runs, and how many bytes each EEPROM fetch returns. A lock bit comes up set out of every hard reset. While it is set, every configuration access arriving on the bus-side port is answered with a retry and has no effect.

The processor-side local port clears the lock with a single pulse. It is a separate input from the bus-side port, so it can never be retried and cannot deadlock. The unlock is honoured only once the load has finished. Finishing the load never clears the lock by itself.

The bus-side request port works on a valid-only basis and is always ready: one request may be presented in every cycle. Each request that is presented in a cycle gets exactly one response in the following cycle, either an acknowledge (with read data) or a retry. The response is a one-cycle pulse with no back-pressure, so the requester must sample it in that cycle. SPI, lock and busy pins are plain control signals.

Top module: `cfg_autoload`

## Requirements
- R1: The configuration word (auto-load enable, 2-bit bus mode, 2-bit port size) is sampled on every clock while `hrst_n` is low. Changes on those inputs after release have no effect until the next hard reset.
- R2: The block is active only when the bus mode equals 2'b01. In any other mode, bus requests get neither acknowledge nor retry, the SPI select stays high, and `loc_unlock` is ignored.
- R3: After hard reset `cfg_lock` reads 1.
- R4: While `cfg_lock` is 1, a bus request presented in cycle N is answered in cycle N+1 with `bus_retry`=1 and `bus_ack`=0. A write made this way leaves the target register unchanged.
- R5: With auto-load enabled, the first EEPROM fetch starts right after release with no other trigger. Each fetch lowers `spi_cs_n` and sends command 0x03 and then a 16-bit unit address, both MSB first. It then reads the data bytes MSB first, in SPI mode 0 with SCLK at half the clock rate.
- R6: Port size 2'b00 fetches 1 byte per unit, 2'b01 fetches 2 bytes, and 2'b10 or 2'b11 fetch 4 bytes. Unit addresses count up from 0, so loading all 16 registers takes 64, 32 or 16 fetches.
- R7: Loaded register r is built from EEPROM bytes 4r to 4r+3, little-endian: byte 4r lands in bits [7:0] and byte 4r+3 in bits [31:24].
- R8: `load_busy` is 1 from release until the last register is loaded and the EEPROM is deselected. With auto-load disabled it falls one cycle after release, all registers read zero and no SPI fetch occurs.
- R9: Completing the load leaves `cfg_lock` at 1. A `loc_unlock` pulse clears it only while `load_busy` is 0; a pulse during the load is ignored.
- R10: With `cfg_lock` at 0, a read returns `bus_ack`=1 and the register contents in the next cycle. A write updates the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, synchronous |
| rcw_auto_en | input | 1 | Configuration word: EEPROM load enable |
| rcw_bus_mode | input | 2 | Configuration word: bus mode, 2'b01 = active |
| rcw_port_size | input | 2 | Configuration word: bytes per EEPROM fetch |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI select, active low |
| spi_mosi | output | 1 | SPI data to EEPROM |
| spi_miso | input | 1 | SPI data from EEPROM |
| bus_req | input | 1 | Bus-side request valid |
| bus_we | input | 1 | Bus-side write (1) or read (0) |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response: access done |
| bus_retry | output | 1 | Response: retry later |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| loc_unlock | input | 1 | Local-port pulse that clears the lock |
| cfg_lock | output | 1 | Lock status |
| load_busy | output | 1 | Auto-load in progress |

## Verification
The load is run with each port size, including the 2'b11 alias, using a different EEPROM byte pattern each time. Matching register contents then separate byte ordering from fetch-unit addressing, and the fetch count separates the three port sizes. Further runs use auto-load disabled and two inactive bus modes, with the configuration inputs scrambled after release. These tell a word captured at reset apart from one that follows its live inputs. Randomly mixed reads and writes are checked against a model, both while locked and after unlock. Directed unlock pulses during and after the load separate a lock that is released too early from one that never opens.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam logic [1:0] BUS_MODE_ON  = 2'b01;
  localparam logic [7:0] SPI_RD_CMD   = 8'h03;

  typedef struct packed {
    logic       auto_en;
    logic [1:0] bus_mode;
    logic [1:0] port_size;
  } rcw_t;

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_END} eng_st_t;
  typedef enum logic [1:0] {S_INIT, S_LAUNCH, S_WAIT, S_DONE} seq_st_t;

  function automatic logic [2:0] fetch_bytes(input logic [1:0] ps);
    case (ps)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfgld_spi_rd.sv
module cfgld_spi_rd
  import cfgld_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        nbytes,
  output logic              done,
  output logic              byte_vld,
  output logic [7:0]        byte_dat,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int HDR_W = 8 + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W + 33);

  eng_st_t          st;
  logic [HDR_W-1:0] tx_sr;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] last_bit;
  logic [6:0]       rx_sr;
  logic [2:0]       dbit;
  logic             sclk_q;
  logic             cs_q;

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = tx_sr[HDR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      tx_sr    <= '0;
      bit_cnt  <= '0;
      last_bit <= '0;
      rx_sr    <= '0;
      dbit     <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      done     <= 1'b0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      done     <= 1'b0;
      byte_vld <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            tx_sr    <= {SPI_RD_CMD, addr};
            bit_cnt  <= '0;
            dbit     <= '0;
            last_bit <= CNT_W'(HDR_W) + CNT_W'({nbytes, 3'b000}) - 1'b1;
            cs_q     <= 1'b0;
            sclk_q   <= 1'b0;
            st       <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q  <= 1'b0;
            tx_sr   <= {tx_sr[HDR_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt >= CNT_W'(HDR_W)) begin
              rx_sr <= {rx_sr[5:0], spi_miso};
              dbit  <= dbit + 1'b1;
              if (dbit == 3'd7) begin
                byte_vld <= 1'b1;
                byte_dat <= {rx_sr, spi_miso};
              end
            end
            if (bit_cnt == last_bit) begin
              cs_q <= 1'b1;
              st   <= E_END;
            end
          end
        end
        E_END: begin
          done <= 1'b1;
          st   <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_SCLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R5

  AST_SELECT_HELD_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_SHIFT) |-> !spi_cs_n); // R5

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int REG_CNT = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go_load,
  input  logic [2:0]                 unit_bytes,
  output logic                       eng_start,
  output logic [ADDR_W-1:0]          eng_addr,
  output logic [2:0]                 eng_nbytes,
  input  logic                       eng_done,
  input  logic                       byte_vld,
  input  logic [7:0]                 byte_dat,
  output logic                       wr_en,
  output logic [$clog2(REG_CNT)-1:0] wr_idx,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       busy
);

  localparam int IDX_W = $clog2(REG_CNT);
  localparam int BPR   = DATA_W / 8;
  localparam int BC_W  = (BPR > 1) ? $clog2(BPR) : 1;

  seq_st_t          st;
  logic [ADDR_W-1:0] unit_addr;
  logic [IDX_W-1:0]  reg_idx;
  logic [BC_W-1:0]   byte_cnt;
  logic [DATA_W-1:0] acc;
  logic              all_wr;

  assign eng_addr   = unit_addr;
  assign eng_nbytes = unit_bytes;
  assign busy       = (st != S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_INIT;
      unit_addr <= '0;
      reg_idx   <= '0;
      byte_cnt  <= '0;
      acc       <= '0;
      all_wr    <= 1'b0;
      eng_start <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      eng_start <= 1'b0;
      wr_en     <= 1'b0;
      case (st)
        S_INIT:   st <= go_load ? S_LAUNCH : S_DONE;
        S_LAUNCH: begin
          eng_start <= 1'b1;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (byte_vld) begin
            acc      <= {byte_dat, acc[DATA_W-1:8]};
            byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == BC_W'(BPR - 1)) begin
              wr_en    <= 1'b1;
              wr_idx   <= reg_idx;
              wr_data  <= {byte_dat, acc[DATA_W-1:8]};
              reg_idx  <= reg_idx + 1'b1;
              byte_cnt <= '0;
              if (reg_idx == IDX_W'(REG_CNT - 1)) all_wr <= 1'b1;
            end
          end
          if (eng_done) begin
            unit_addr <= unit_addr + 1'b1;
            st        <= all_wr ? S_DONE : S_LAUNCH;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  AST_NO_LOAD_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en); // R8

  AST_NO_FETCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !go_load |-> !eng_start); // R8

endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
  parameter int REG_CNT = 16,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic                       busy,
  input  logic                       ld_we,
  input  logic [$clog2(REG_CNT)-1:0] ld_idx,
  input  logic [DATA_W-1:0]          ld_data,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [$clog2(REG_CNT)-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       loc_unlock,
  output logic                       bus_ack,
  output logic                       bus_retry,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       lock
);

  localparam int IDX_W = $clog2(REG_CNT);

  logic [REG_CNT-1:0][DATA_W-1:0] regs;
  logic                           take;

  assign take = active && bus_req && !lock;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (ld_we && ld_idx == IDX_W'(g)) begin
        regs[g] <= ld_data;
      end else if (take && bus_we && bus_addr == IDX_W'(g)) begin
        regs[g] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock      <= 1'b1;
      bus_ack   <= 1'b0;
      bus_retry <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (loc_unlock && active && !busy) lock <= 1'b0;
      bus_ack   <= take;
      bus_retry <= active && bus_req && lock;
      bus_rdata <= (take && !bus_we) ? regs[bus_addr] : '0;
    end
  end

  AST_LOCKED_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && bus_req && active) |=> (bus_retry && !bus_ack)); // R4

  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_retry)); // R4

  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !ld_we) |=> $stable(regs)); // R4

  AST_LOCK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lock) |=> lock); // R9

endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfgld_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 32,
  parameter int EE_ADDR_W = 16
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              rcw_auto_en,
  input  logic [1:0]        rcw_bus_mode,
  input  logic [1:0]        rcw_port_size,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic              bus_retry,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              loc_unlock,
  output logic              cfg_lock,
  output logic              load_busy
);

  localparam int REG_CNT = 1 << REG_AW;

  rcw_t rcw_q;
  logic run_q;
  logic active;
  logic go_load;

  always_ff @(posedge clk) begin
    if (!hrst_n) begin
      rcw_q <= '{auto_en: rcw_auto_en, bus_mode: rcw_bus_mode, port_size: rcw_port_size};
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  assign active  = (rcw_q.bus_mode == BUS_MODE_ON);
  assign go_load = active && rcw_q.auto_en;

  logic                 eng_start, eng_done, byte_vld;
  logic [EE_ADDR_W-1:0] eng_addr;
  logic [2:0]           eng_nbytes;
  logic [7:0]           byte_dat;
  logic                 ld_we;
  logic [REG_AW-1:0]    ld_idx;
  logic [DATA_W-1:0]    ld_data;

  cfgld_seq #(
    .REG_CNT (REG_CNT),
    .DATA_W  (DATA_W),
    .ADDR_W  (EE_ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (hrst_n),
    .go_load    (go_load),
    .unit_bytes (fetch_bytes(rcw_q.port_size)),
    .eng_start  (eng_start),
    .eng_addr   (eng_addr),
    .eng_nbytes (eng_nbytes),
    .eng_done   (eng_done),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat),
    .wr_en      (ld_we),
    .wr_idx     (ld_idx),
    .wr_data    (ld_data),
    .busy       (load_busy)
  );

  cfgld_spi_rd #(
    .ADDR_W (EE_ADDR_W)
  ) u_spi (
    .clk      (clk),
    .rst_n    (hrst_n),
    .start    (eng_start),
    .addr     (eng_addr),
    .nbytes   (eng_nbytes),
    .done     (eng_done),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso)
  );

  cfgld_regs #(
    .REG_CNT (REG_CNT),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (hrst_n),
    .active     (active),
    .busy       (load_busy),
    .ld_we      (ld_we),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .loc_unlock (loc_unlock),
    .bus_ack    (bus_ack),
    .bus_retry  (bus_retry),
    .bus_rdata  (bus_rdata),
    .lock       (cfg_lock)
  );

  AST_RCW_FROZEN: assert property (@(posedge clk) disable iff (!hrst_n)
    run_q |-> $stable(rcw_q)); // R1

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!hrst_n)
    !active |-> (!bus_ack && !bus_retry && spi_cs_n && cfg_lock)); // R2

endmodule

// File: tb/sim_cfg_autoload.sv
module sim_cfg_autoload;

  logic        clk = 1'b0;
  logic        hrst_n = 1'b0;
  logic        rcw_auto_en = 1'b0;
  logic [1:0]  rcw_bus_mode = 2'b00;
  logic [1:0]  rcw_port_size = 2'b00;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack, bus_retry;
  logic [31:0] bus_rdata;
  logic        loc_unlock = 1'b0;
  logic        cfg_lock, load_busy;

  always #4 clk = ~clk;

  cfg_autoload u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cur_salt = 0;
  int cur_nb = 1;
  int txn_cnt = 0;
  int bad_hdr = 0;
  int exp_unit = 0;
  int rise_cnt = 0;
  logic [23:0] hdr = '0;
  logic [31:0] mdl [16];

  function automatic logic [7:0] ee_byte(input int salt, input int a);
    return 8'(((a * 29) + (salt * 7)) ^ (a >> 3) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] exp_reg(input int salt, input int r);
    return {ee_byte(salt, 4*r+3), ee_byte(salt, 4*r+2), ee_byte(salt, 4*r+1), ee_byte(salt, 4*r)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // EEPROM model: SPI mode 0, read command with 16-bit unit address
  always @(negedge spi_cs_n) begin
    rise_cnt = 0;
    hdr = '0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (rise_cnt < 24) hdr = {hdr[22:0], spi_mosi};
      rise_cnt++;
      if (rise_cnt == 24) begin
        if (hdr[23:16] !== 8'h03 || hdr[15:0] !== 16'(exp_unit)) bad_hdr++;
        exp_unit++;
        txn_cnt++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    int di;
    logic [7:0] b;
    if (!spi_cs_n && rise_cnt >= 24) begin
      di = rise_cnt - 24;
      b = ee_byte(cur_salt, int'(hdr[15:0]) * cur_nb + di / 8);
      spi_miso <= b[7 - (di % 8)];
    end
  end

  task automatic bus_access(input logic we, input logic [3:0] a, input logic [31:0] d,
                            output logic ack, output logic rty, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    ack = bus_ack; rty = bus_retry; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse_unlock();
    @(negedge clk); loc_unlock = 1'b1;
    @(negedge clk); loc_unlock = 1'b0;
  endtask

  task automatic run_case(input logic ae, input logic [1:0] mode, input logic [1:0] ps, input int salt);
    logic ack, rty;
    logic [31:0] rd;
    int guard;
    cur_salt = salt;
    cur_nb = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 2 : 4;
    txn_cnt = 0; bad_hdr = 0; exp_unit = 0;
    @(negedge clk);
    hrst_n = 1'b0; rcw_auto_en = ae; rcw_bus_mode = mode; rcw_port_size = ps;
    repeat (4) @(negedge clk);
    hrst_n = 1'b1;
    // R1: scramble the configuration inputs after release
    rcw_auto_en = ~ae; rcw_bus_mode = ~mode; rcw_port_size = ~ps;
    @(negedge clk);
    chk("R3 lock after reset", 32'(cfg_lock), 32'd1);
    if (mode != 2'b01) begin
      for (int i = 0; i < 4; i++) begin
        bus_access($urandom % 2, 4'($urandom), $urandom, ack, rty, rd);
        chk("R2 inactive no response", {30'd0, ack, rty}, 32'd0);
      end
      pulse_unlock();
      chk("R2 unlock ignored when inactive", 32'(cfg_lock), 32'd1);
      chk("R1 R2 no fetch when inactive", 32'(txn_cnt), 32'd0);
      return;
    end
    if (!ae) begin
      chk("R8 busy low without load", 32'(load_busy), 32'd0);
      repeat (20) @(negedge clk);
      chk("R8 R1 no fetch without load", 32'(txn_cnt), 32'd0);
      pulse_unlock();
      chk("R9 unlock when idle", 32'(cfg_lock), 32'd0);
      for (int r = 0; r < 16; r++) begin
        bus_access(1'b0, 4'(r), '0, ack, rty, rd);
        chk("R8 default zero", rd, 32'd0);
      end
      return;
    end
    chk("R8 busy after release", 32'(load_busy), 32'd1);
    for (int i = 0; i < 5; i++) begin
      bus_access($urandom % 2, 4'($urandom), $urandom, ack, rty, rd);
      chk("R4 retry while loading", {30'd0, ack, rty}, 32'd1);
    end
    pulse_unlock();
    chk("R9 unlock ignored while busy", 32'(cfg_lock), 32'd1);
    guard = 0;
    while (load_busy && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk("R8 load finishes", 32'(load_busy), 32'd0);
    chk("R6 fetch count", 32'(txn_cnt), 32'(64 / cur_nb));
    chk("R5 command and address", 32'(bad_hdr), 32'd0);
    chk("R9 lock kept after load", 32'(cfg_lock), 32'd1);
    bus_access(1'b1, 4'd5, 32'hDEAD_BEEF, ack, rty, rd);
    chk("R4 locked write retried", {30'd0, ack, rty}, 32'd1);
    pulse_unlock();
    chk("R9 unlock after load", 32'(cfg_lock), 32'd0);
    for (int r = 0; r < 16; r++) begin
      bus_access(1'b0, 4'(r), '0, ack, rty, rd);
      chk("R10 read ack", {30'd0, ack, rty}, 32'd2);
      chk(r == 5 ? "R4 R7 locked write had no effect" : "R7 loaded value", rd, exp_reg(salt, r));
      mdl[r] = exp_reg(salt, r);
    end
    for (int i = 0; i < 24; i++) begin
      logic we;
      logic [3:0] a;
      logic [31:0] d;
      we = 1'($urandom); a = 4'($urandom); d = $urandom;
      bus_access(we, a, d, ack, rty, rd);
      chk("R10 ack unlocked", {30'd0, ack, rty}, 32'd2);
      if (we) mdl[a] = d;
      else chk("R10 read data", rd, mdl[a]);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    run_case(1'b1, 2'b01, 2'b00, 3);
    run_case(1'b1, 2'b01, 2'b01, 11);
    run_case(1'b1, 2'b01, 2'b10, 27);
    run_case(1'b1, 2'b01, 2'b11, 40);
    run_case(1'b0, 2'b01, 2'b10, 5);
    run_case(1'b1, 2'b00, 2'b10, 6);
    run_case(1'b1, 2'b11, 2'b00, 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule